// File: doc/BRIEF.md
# Slave-Mode Serial Audio Frame Port

This block is the digital end of a codec's serial sample link when an outside host owns the timing. The host supplies the bit clock and the frame strobe. In each frame the block receives one 16-bit playback word on `sdi` and returns one 16-bit record word on `sdo`. It samples the three link inputs in the local `clk` domain through a synchronizer chain. It then tracks bit-clock edges to work out where it is in the frame.

Two frame shapes are supported, selected by the static `short_mode` pin:
- **Full frame:** 32 bit clocks split into two 16-clock slots. `slot_sel` names the slot that carries data.
- **Compact frame:** 17 bit clocks. A single idle clock is followed by one 16-clock data slot.

The word to send is taken from `tx_word` when a frame opens. The received word appears on `rx_word` with a one-cycle `rx_valid` strobe.

Top module: `csp_audio_port`

## Requirements
- R1: After reset, `sdo`, `rx_valid`, `rx_word` and `frame_err` are all zero.
- R2: Bits on `sdi` are captured at falling bit-clock edges of the data slot, MSB first. After the last data bit, `rx_word` holds the host's 16-bit word.
- R3: `sdo` takes its next value a few `clk` cycles after each rising bit-clock edge, MSB first, from the `tx_word` value captured at the first rising bit-clock edge after a frame-strobe rise. Later changes of `tx_word` do not alter the frame in progress.
- R4: With `short_mode`=0 the frame is 32 bit clocks (cycles 0 to 31). `slot_sel`=0 places data in cycles 0 to 15 and `slot_sel`=1 places it in cycles 16 to 31.
- R5: With `short_mode`=1 the frame is 17 bit clocks. Cycle 0 carries no data, cycles 1 to 16 carry the word, and `slot_sel` has no effect.
- R6: `sdo` is 0 in every cycle of a frame that is outside the data slot.
- R7: `rx_valid` is a single `clk` cycle pulse, issued exactly once per frame whose data slot completes.
- R8: Bit clocks beyond the frame length, up to the next strobe rise, leave `sdo` at 0 and produce no `rx_valid`.
- R9: A strobe rise before the current frame has run its full length restarts the frame and discards any partial received word. It also sets `frame_err`, which stays set until reset.
- R10: Bit clocks that arrive before the first strobe rise after reset are ignored. `sdo` stays 0 and no `rx_valid` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Bit clock from the host |
| fsync | input | 1 | Frame strobe from the host; a rise opens a frame |
| sdi | input | 1 | Serial playback data from the host |
| short_mode | input | 1 | 0: 32-clock frame, 1: 17-clock frame |
| slot_sel | input | 1 | Data slot in the 32-clock frame: 0 first, 1 second |
| tx_word | input | 16 | Record word to send, captured at frame start |
| sdo | output | 1 | Serial record data to the host |
| rx_word | output | 16 | Last completely received playback word |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` is updated |
| frame_err | output | 1 | Sticky flag for a frame cut short by a new strobe |

## Verification
The main exchange is tried in several configurations: each slot of the full frame, the compact frame, and walking-one and all-ones/all-zeros words. These tell a bit-order or slot-offset mistake apart from a stuck line. Outside the data slot the host drives random junk on `sdi`, so capture in the wrong cycle corrupts the received word. Frames are also run longer than their nominal length, to separate ignored trailing clocks from counted ones. Truncated frames followed by a new strobe separate a clean restart from a leaked partial word. Changing `tx_word` mid-frame shows whether the capture happens only at frame start.

// File: rtl/csp_pkg.sv
package csp_pkg;

   // True when bit cycle c lies inside a data slot of width w starting at base.
   function automatic logic csp_in_slot(input int unsigned c, input int unsigned base,
                                        input int unsigned w);
      return (c >= base) && (c < base + w);
   endfunction

endpackage

// File: rtl/csp_sync.sv
module csp_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= '0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/csp_frame_ctrl.sv
module csp_frame_ctrl
   import csp_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_rise,
   input  logic             bclk_fall,
   input  logic             fs_rise,
   input  logic             short_mode,
   input  logic             slot_sel,
   output logic             start,
   output logic             rise_ev,
   output logic             next_data,
   output logic             done,
   output logic             cap_en,
   output logic             cap_last,
   output logic             active,
   output logic             frame_err,
   output logic [CNT_W-1:0] cnt
);
   localparam int LONG_LEN  = 2 * DATA_W;
   localparam int SHORT_LEN = DATA_W + 1;

   logic             pending;
   logic [CNT_W-1:0] slot_base;
   logic [CNT_W-1:0] last_idx;
   logic [CNT_W-1:0] nxt_cnt;
   logic             cur_data;

   always_comb begin
      if (short_mode)    slot_base = CNT_W'(1);
      else if (slot_sel) slot_base = CNT_W'(DATA_W);
      else               slot_base = '0;
      last_idx  = short_mode ? CNT_W'(SHORT_LEN - 1) : CNT_W'(LONG_LEN - 1);
      start     = bclk_rise & (pending | fs_rise);
      rise_ev   = bclk_rise & (start | active);
      nxt_cnt   = start ? '0 : cnt + CNT_W'(1);
      next_data = csp_in_slot(32'(nxt_cnt), 32'(slot_base), DATA_W);
      cur_data  = csp_in_slot(32'(cnt), 32'(slot_base), DATA_W);
      done      = bclk_fall & active & (cnt == last_idx);
      cap_en    = bclk_fall & active & cur_data;
      cap_last  = cap_en & (cnt == slot_base + CNT_W'(DATA_W - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending   <= 1'b0;
         active    <= 1'b0;
         frame_err <= 1'b0;
         cnt       <= '0;
      end else begin
         if (start)        pending <= 1'b0;
         else if (fs_rise) pending <= 1'b1;

         if (start) begin
            cnt    <= '0;
            active <= 1'b1;
            if (active) frame_err <= 1'b1;
         end else if (rise_ev) begin
            cnt <= nxt_cnt;
         end else if (done) begin
            active <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/csp_tx_shift.sv
module csp_tx_shift #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rise_ev,
   input  logic              next_data,
   input  logic              done,
   input  logic [DATA_W-1:0] tx_word,
   output logic              sdo
);
   logic [DATA_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         sdo <= 1'b0;
      end else if (start) begin
         if (next_data) begin
            sdo <= tx_word[DATA_W-1];
            sh  <= {tx_word[DATA_W-2:0], 1'b0};
         end else begin
            sdo <= 1'b0;
            sh  <= tx_word;
         end
      end else if (rise_ev) begin
         if (next_data) begin
            sdo <= sh[DATA_W-1];
            sh  <= {sh[DATA_W-2:0], 1'b0};
         end else begin
            sdo <= 1'b0;
         end
      end else if (done) begin
         sdo <= 1'b0;
      end
   end
endmodule

// File: rtl/csp_rx_shift.sv
module csp_rx_shift #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cap_en,
   input  logic              cap_last,
   input  logic              sdi_s,
   output logic [DATA_W-1:0] rx_word,
   output logic              rx_valid
);
   logic [DATA_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh       <= '0;
         rx_word  <= '0;
         rx_valid <= 1'b0;
      end else begin
         if (start)       sh <= '0;
         else if (cap_en) sh <= {sh[DATA_W-2:0], sdi_s};
         rx_valid <= cap_last;
         if (cap_last) rx_word <= {sh[DATA_W-2:0], sdi_s};
      end
   end
endmodule

// File: rtl/csp_audio_port.sv
module csp_audio_port #(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk,
   input  logic              fsync,
   input  logic              sdi,
   input  logic              short_mode,
   input  logic              slot_sel,
   input  logic [DATA_W-1:0] tx_word,
   output logic              sdo,
   output logic [DATA_W-1:0] rx_word,
   output logic              rx_valid,
   output logic              frame_err
);
   localparam int LONG_LEN = 2 * DATA_W;
   localparam int CNT_W    = $clog2(LONG_LEN + 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("csp_audio_port: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("csp_audio_port: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [2:0]       link_s;
   logic             bclk_s, fs_s, sdi_s;
   logic             bclk_d, fs_d;
   logic             bclk_rise, bclk_fall, fs_rise;
   logic             start, rise_ev, next_data, done, cap_en, cap_last, active;
   logic [CNT_W-1:0] cnt;

   csp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({bclk, fsync, sdi}), .q(link_s)
   );

   assign {bclk_s, fs_s, sdi_s} = link_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_d <= 1'b0;
         fs_d   <= 1'b0;
      end else begin
         bclk_d <= bclk_s;
         fs_d   <= fs_s;
      end
   end

   assign bclk_rise = bclk_s & ~bclk_d;
   assign bclk_fall = ~bclk_s & bclk_d;
   assign fs_rise   = fs_s & ~fs_d;

   csp_frame_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
      .fs_rise(fs_rise), .short_mode(short_mode), .slot_sel(slot_sel),
      .start(start), .rise_ev(rise_ev), .next_data(next_data), .done(done),
      .cap_en(cap_en), .cap_last(cap_last), .active(active),
      .frame_err(frame_err), .cnt(cnt)
   );

   csp_tx_shift #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .rise_ev(rise_ev),
      .next_data(next_data), .done(done), .tx_word(tx_word), .sdo(sdo)
   );

   csp_rx_shift #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .start(start), .cap_en(cap_en),
      .cap_last(cap_last), .sdi_s(sdi_s), .rx_word(rx_word), .rx_valid(rx_valid)
   );
endmodule

// File: rtl/csp_checker.sv
module csp_checker #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sdo,
   input logic              rx_valid,
   input logic [DATA_W-1:0] rx_word,
   input logic              frame_err,
   input logic              active,
   input logic [CNT_W-1:0]  cnt
);
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);                                     // R7
   AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(active));                                 // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err);                                    // R9
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_word != $past(rx_word)) |-> rx_valid);                   // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !sdo);                                           // R8
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt < CNT_W'(2 * DATA_W)));                      // R4
endmodule

bind csp_audio_port csp_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sdo(sdo), .rx_valid(rx_valid), .rx_word(rx_word),
   .frame_err(frame_err), .active(active), .cnt(cnt)
);

// File: tb/csp_audio_port_bench.sv
`timescale 1ns/1ps
module csp_audio_port_bench;
   localparam int H = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0;
   logic        fsync = 1'b0;
   logic        sdi = 1'b0;
   logic        short_mode = 1'b0;
   logic        slot_sel = 1'b0;
   logic [15:0] tx_word = '0;
   logic        sdo;
   logic [15:0] rx_word;
   logic        rx_valid;
   logic        frame_err;

   int          checks = 0;
   int          failures = 0;
   int          vcount = 0;
   logic [15:0] vword = '0;
   bit          finished = 1'b0;
   bit          exp_err = 1'b0;
   bit          prev_short = 1'b0;

   csp_audio_port u_csp_audio_port (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdi(sdi),
      .short_mode(short_mode), .slot_sel(slot_sel), .tx_word(tx_word),
      .sdo(sdo), .rx_word(rx_word), .rx_valid(rx_valid), .frame_err(frame_err)
   );

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         vcount = vcount + 1;
         vword  = rx_word;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int base_of(input bit mode, input bit sel);
      return mode ? 1 : (sel ? 16 : 0);
   endfunction

   function automatic int len_of(input bit mode);
      return mode ? 17 : 32;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; bclk = 1'b0; fsync = 1'b0; sdi = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      exp_err = 1'b0;
      prev_short = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic run_frame(input bit mode, input bit sel, input logic [15:0] txw,
                            input logic [15:0] hw, input int ncyc, input bit mutate);
      int base = base_of(mode, sel);
      int len  = len_of(mode);
      int v0   = vcount;
      bit full;
      short_mode = mode;
      slot_sel   = sel;
      tx_word    = txw;
      if (prev_short) exp_err = 1'b1;
      for (int c = 0; c < ncyc; c++) begin
         bit indata = (c < len) && (c >= base) && (c < base + 16);
         logic exp_bit = indata ? txw[15 - (c - base)] : 1'b0;
         string req;
         @(negedge clk);
         bclk  = 1'b1;
         fsync = (c < 2);
         sdi   = indata ? hw[15 - (c - base)] : 1'($urandom);
         repeat (H) @(negedge clk);
         if (c == 0 && mutate) tx_word = ~txw;
         if (c >= len)   req = "R8";
         else if (mode)  req = "R5";
         else if (indata) req = "R3";
         else             req = "R6";
         check(sdo === exp_bit, req, $sformatf("sdo cycle %0d", c), int'(sdo), int'(exp_bit));
         bclk = 1'b0;
         repeat (H) @(negedge clk);
      end
      fsync = 1'b0;
      repeat (2 * H) @(negedge clk);
      full = (ncyc >= base + 16);
      check(vcount - v0 == (full ? 1 : 0), full ? "R7" : "R9", "rx_valid count",
            vcount - v0, full ? 1 : 0);
      if (full) check(vword === hw, mode ? "R5" : (sel ? "R4" : "R2"), "rx_word",
                      int'(vword), int'(hw));
      check(frame_err === exp_err, "R9", "frame_err", int'(frame_err), int'(exp_err));
      prev_short = (ncyc < len);
   endtask

   initial begin
      #(150000 * 8);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset();
      // R1: reset state
      check(sdo === 1'b0, "R1", "sdo", int'(sdo), 0);
      check(rx_valid === 1'b0, "R1", "rx_valid", int'(rx_valid), 0);
      check(rx_word === 16'h0, "R1", "rx_word", int'(rx_word), 0);
      check(frame_err === 1'b0, "R1", "frame_err", int'(frame_err), 0);

      // R10: bit clocks without any strobe are ignored
      tx_word = 16'hFFFF;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         bclk = 1'b1; sdi = 1'($urandom);
         repeat (H) @(negedge clk);
         check(sdo === 1'b0, "R10", "sdo before first strobe", int'(sdo), 0);
         bclk = 1'b0;
         repeat (H) @(negedge clk);
      end
      check(vcount == 0, "R10", "rx_valid before first strobe", vcount, 0);

      // directed corner cases
      run_frame(1'b0, 1'b0, 16'hA5C3, 16'h8001, 32, 1'b0);   // R2 R4 first slot
      run_frame(1'b0, 1'b1, 16'hFFFF, 16'h0000, 32, 1'b0);   // R4 second slot
      run_frame(1'b0, 1'b1, 16'h0000, 16'hFFFF, 32, 1'b0);
      run_frame(1'b1, 1'b0, 16'h8000, 16'h0001, 17, 1'b0);   // R5
      run_frame(1'b1, 1'b1, 16'h1234, 16'hFEDC, 17, 1'b0);   // R5 slot_sel ignored
      run_frame(1'b0, 1'b0, 16'h5A5A, 16'h3C3C, 32, 1'b1);   // R3 mid-frame tx change
      run_frame(1'b0, 1'b1, 16'h0F0F, 16'hC001, 36, 1'b0);   // R8 trailing clocks
      run_frame(1'b1, 1'b0, 16'h7E81, 16'h4002, 21, 1'b0);   // R8 compact trailing

      // R9: cut-short frame then restart
      run_frame(1'b0, 1'b1, 16'h1111, 16'h2222, 10, 1'b0);
      run_frame(1'b0, 1'b1, 16'h3333, 16'hBEEF, 32, 1'b0);
      run_frame(1'b1, 1'b0, 16'h4444, 16'h9999, 17, 1'b0);   // flag stays set
      do_reset();
      check(frame_err === 1'b0, "R1", "frame_err after reset", int'(frame_err), 0);

      // constrained random frames
      for (int n = 0; n < 24; n++) begin
         bit   m   = 1'($urandom);
         bit   s   = 1'($urandom);
         int   len = len_of(m);
         int   r   = $urandom_range(0, 9);
         int   nc  = (r == 0) ? $urandom_range(3, len - 1) : len + $urandom_range(0, 3);
         run_frame(m, s, 16'($urandom), 16'($urandom), nc, 1'($urandom));
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule